// File: doc/BRIEF.md
# Priority Interrupt Resolver with Vectoring

This block is the decision core of an eight-line interrupt controller. Each line's request is captured in a request register, either on a rising edge or by following the level of the input, depending on a mode flag. A mask register turns individual lines off. The block picks the lowest-numbered unmasked pending line. If that line outranks every line currently being serviced, the block raises its interrupt output.

The processor acknowledges the interrupt with a one-cycle `inta` pulse. On the following cycle the block presents an 8-bit vector, formed from a 5-bit programmed base followed by the 3-bit line number. At the same clock edge it marks the line as in service, unless automatic end-of-interrupt is selected. An in-service mark is removed by an end-of-interrupt command that names the line. The vector base, trigger mode and auto-EOI flag arrive already decoded from a separate initialisation sequencer.

The control flow is a three-state machine:

- `ST_IDLE` moves to `ST_RAISE` when an eligible request exists (transition "eligible").
- `ST_RAISE` drives `irq_out`. It returns to `ST_IDLE` when no request outranks the in-service lines any more (transition "withdrawn"). It moves to `ST_VECTOR` when `inta` is sampled while the request is still eligible (transition "taken").
- `ST_VECTOR` drives `vec_valid` and `vec_out` for one cycle and always returns to `ST_IDLE` (transition "delivered").

Top module: `irq_resolver`

## Requirements
- R1: After reset, `irq_out` and `vec_valid` are 0, `vec_out` is 0, nothing is in service, and the mask register is all ones, so every line is disabled.
- R2: Mask bit k set to 1 disables line k. A mask write via `mask_we` takes effect at the next clock. Unmasking a line with a latched request raises `irq_out`, and masking the only eligible line withdraws it.
- R3: Fixed priority applies: line 0 is highest and line 7 lowest, so the lowest-numbered eligible line is granted first.
- R4: The cycle after `inta` is sampled high while `irq_out` is high, `vec_valid` is 1 for exactly one cycle. In that cycle `vec_out` = {`vec_base`[4:0], line[2:0]}, so with base 5'h04 line 0 gives 0x20 and line 7 gives 0x27.
- R5: With `level_mode`=0, a 0-to-1 transition on a request input is latched and stays pending after the input falls. It is cleared when that line is acknowledged.
- R6: With `level_mode`=1, the request follows the input. Dropping the input before acknowledge withdraws `irq_out`, and a line still held high is requested again once it leaves service.
- R7: A pending line interrupts only if it is strictly higher in priority than every in-service line. When that stops being true, `irq_out` falls within two clocks.
- R8: With `auto_eoi`=0, an acknowledged line stays in service until an EOI (`eoi_valid` with `eoi_line`) names that line. An EOI naming another line leaves it in service.
- R9: With `auto_eoi`=1, acknowledge does not mark the line in service, so lower lines and new requests on the same line are granted without any EOI.
- R10: A mask write never clears an in-service mark.
- R11: `inta` while `irq_out` is low is ignored and produces no `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Request inputs, bit k is line k |
| vec_base | input | 5 | Upper five bits of the vector |
| level_mode | input | 1 | 1 = level-sensitive requests, 0 = rising edge |
| auto_eoi | input | 1 | 1 = no in-service mark after acknowledge |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask, 1 disables a line |
| eoi_valid | input | 1 | Specific end-of-interrupt command |
| eoi_line | input | 3 | Line whose in-service mark is cleared |
| inta | input | 1 | Acknowledge pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | 8 | Vector of the acknowledged line |

## Verification
Multi-line request patterns (lines 2, 5 and 7 together) with auto-EOI separate correct fixed priority from any other grant order. They also show that acknowledging one line leaves the rest pending. Nested sequences raise a low line and then a higher one while a middle line is in service. These distinguish the strict outranking rule from a plain pending check, and show EOI acting on the named line only. Single-cycle pulses on a masked line, and level inputs dropped before acknowledge, separate edge latching from level following. Mask writes made while a line is in service show that masking and service tracking are independent.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISE  = 2'd1,
        ST_VECTOR = 2'd2
    } rsv_state_e;
endpackage

// File: rtl/rsv_prio_pick.sv
// Finds the lowest-numbered set bit (highest priority).
module rsv_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rsv_req_latch.sv
// Request register: edge-latched or level-following per line.
module rsv_req_latch #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level_mode,
    input  logic [N-1:0]  req_in,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  irr
);
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    assign rise = req_in & ~req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                irr[g] <= 1'b0;
            else if (level_mode)
                irr[g] <= req_in[g];
            else
                irr[g] <= rise[g] | (irr[g] & ~(clr_en && (clr_idx == IW'(g))));
        end
    end
endmodule

// File: rtl/rsv_service_reg.sv
// In-service register: set on acknowledge, cleared by specific EOI.
module rsv_service_reg #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          eoi_en,
    input  logic [IW-1:0] eoi_idx,
    output logic [N-1:0]  isr
);
    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                isr[g] <= 1'b0;
            else if (set_en && (set_idx == IW'(g)))
                isr[g] <= 1'b1;
            else if (eoi_en && (eoi_idx == IW'(g)))
                isr[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_resolver_pkg::*;
#(
    parameter  int N_LINES = 8,
    parameter  int VEC_W   = 8,
    localparam int IDX_W   = $clog2(N_LINES),
    localparam int BASE_W  = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_in,
    input  logic [BASE_W-1:0]  vec_base,
    input  logic               level_mode,
    input  logic               auto_eoi,
    input  logic               mask_we,
    input  logic [N_LINES-1:0] mask_wdata,
    input  logic               eoi_valid,
    input  logic [IDX_W-1:0]   eoi_line,
    input  logic               inta,
    output logic               irq_out,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    rsv_state_e         state_q, state_d;
    logic [N_LINES-1:0] irr, isr_q, imr_q, pending;
    logic               cand_found, svc_found, outranks, take;
    logic [IDX_W-1:0]   cand_idx, svc_idx, grant_q;

    // Mask register: resets to all lines disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       imr_q <= '1;
        else if (mask_we) imr_q <= mask_wdata;
    end

    rsv_req_latch #(.N(N_LINES), .IW(IDX_W)) u_req (
        .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .req_in(req_in),
        .clr_en(take), .clr_idx(cand_idx), .irr(irr)
    );

    assign pending = irr & ~imr_q;

    rsv_prio_pick #(.N(N_LINES), .IW(IDX_W)) u_pick_req (
        .vec(pending), .found(cand_found), .idx(cand_idx)
    );

    rsv_prio_pick #(.N(N_LINES), .IW(IDX_W)) u_pick_svc (
        .vec(isr_q), .found(svc_found), .idx(svc_idx)
    );

    assign outranks = cand_found && (!svc_found || (cand_idx < svc_idx));
    assign take     = (state_q == ST_RAISE) && outranks && inta;

    rsv_service_reg #(.N(N_LINES), .IW(IDX_W)) u_svc (
        .clk(clk), .rst_n(rst_n), .set_en(take && !auto_eoi), .set_idx(cand_idx),
        .eoi_en(eoi_valid), .eoi_idx(eoi_line), .isr(isr_q)
    );

    // State register and granted line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) grant_q <= cand_idx;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (outranks) state_d = ST_RAISE;
            ST_RAISE: begin
                if (!outranks)  state_d = ST_IDLE;
                else if (inta)  state_d = ST_VECTOR;
            end
            ST_VECTOR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        irq_out   = (state_q == ST_RAISE);
        vec_valid = (state_q == ST_VECTOR);
        vec_out   = vec_valid ? {vec_base, grant_q} : '0;
    end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inta,
    input logic               auto_eoi,
    input logic               eoi_valid,
    input logic [IDX_W-1:0]   eoi_line,
    input logic [VEC_W-IDX_W-1:0] vec_base,
    input logic               irq_out,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_out,
    input logic [N_LINES-1:0] isr
);
    // R11
    ack_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(inta) && $past(irq_out)));

    // R4
    vector_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R4
    vector_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:IDX_W] == vec_base));

    // R10
    service_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_valid |=> ((isr & $past(isr)) == $past(isr)));

    // R8
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !inta) |=> !isr[$past(eoi_line)]);

    // R8
    delivered_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !auto_eoi) |-> isr[vec_out[IDX_W-1:0]]);
endmodule

bind irq_resolver irq_resolver_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .auto_eoi(auto_eoi),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .vec_base(vec_base),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out), .isr(isr_q)
);

// File: tb/irq_resolver_test.sv
module irq_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_in;
    logic [4:0] vec_base;
    logic       level_mode, auto_eoi, mask_we, eoi_valid, inta;
    logic [7:0] mask_wdata;
    logic [2:0] eoi_line;
    logic       irq_out, vec_valid;
    logic [7:0] vec_out;
    int         total = 0;
    int         fails = 0;

    always #10 clk = ~clk;

    irq_resolver uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .vec_base(vec_base),
        .level_mode(level_mode), .auto_eoi(auto_eoi), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
        .inta(inta), .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic lvl, input logic aeoi);
        @(negedge clk);
        rst_n = 1'b0; req_in = '0; vec_base = 5'h04; level_mode = lvl;
        auto_eoi = aeoi; mask_we = 1'b0; mask_wdata = '0; eoi_valid = 1'b0;
        eoi_line = '0; inta = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic write_mask(input logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m;
        step(1);
        mask_we = 1'b0;
    endtask

    task automatic send_eoi(input logic [2:0] l);
        eoi_valid = 1'b1; eoi_line = l;
        step(1);
        eoi_valid = 1'b0;
    endtask

    task automatic ack_expect(input string tag, input logic [7:0] exp);
        inta = 1'b1;
        step(1);
        inta = 1'b0;
        chk({tag, " vec_valid"}, vec_valid, 1);
        chk({tag, " vector"}, vec_out, exp);
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b0);
        chk("R1 irq after reset", irq_out, 0);
        chk("R1 vec_valid after reset", vec_valid, 0);
        chk("R1 vec_out after reset", vec_out, 0);
        req_in = 8'h01;
        step(3);
        chk("R1 all lines masked", irq_out, 0);
    endtask

    task automatic t_edge_mask;
        do_reset(1'b0, 1'b0);
        req_in = 8'h08; step(1); req_in = '0;
        step(2);
        chk("R2 masked pulse", irq_out, 0);
        write_mask(8'hF7);
        step(1);
        chk("R2 R5 unmask latched edge", irq_out, 1);
        ack_expect("R4 line3", 8'h23);
        send_eoi(3'd3);
        step(3);
        chk("R5 edge cleared on ack", irq_out, 0);
    endtask

    task automatic t_priority_auto;
        do_reset(1'b0, 1'b1);
        write_mask(8'h00);
        req_in = 8'hA4; step(2); req_in = '0;
        chk("R3 irq", irq_out, 1);
        ack_expect("R3 first line2", 8'h22);
        step(2);
        ack_expect("R3 R9 second line5", 8'h25);
        step(2);
        ack_expect("R3 R9 third line7", 8'h27);
        step(3);
        chk("R9 all drained", irq_out, 0);
        req_in = 8'h04; step(2); req_in = '0;
        ack_expect("R9 repeat line2 a", 8'h22);
        req_in = 8'h04; step(2); req_in = '0;
        chk("R9 same line again", irq_out, 1);
        ack_expect("R9 repeat line2 b", 8'h22);
    endtask

    task automatic t_nesting;
        do_reset(1'b0, 1'b0);
        write_mask(8'h00);
        req_in = 8'h10; step(2); req_in = '0;
        ack_expect("R4 line4", 8'h24);
        req_in = 8'h40; step(1); req_in = '0;
        step(2);
        chk("R7 lower blocked", irq_out, 0);
        req_in = 8'h02; step(2); req_in = '0;
        chk("R7 higher nests", irq_out, 1);
        ack_expect("R7 line1", 8'h21);
        send_eoi(3'd1);
        step(2);
        chk("R7 line6 still below line4", irq_out, 0);
        send_eoi(3'd3);
        step(2);
        chk("R8 other-line EOI", irq_out, 0);
        send_eoi(3'd4);
        step(1);
        chk("R8 EOI line4 frees line6", irq_out, 1);
        ack_expect("R8 line6", 8'h26);
    endtask

    task automatic t_level;
        do_reset(1'b1, 1'b0);
        vec_base = 5'h1F;
        write_mask(8'h00);
        req_in = 8'h10; step(2);
        chk("R6 level raise", irq_out, 1);
        req_in = '0; step(2);
        chk("R6 level withdraw", irq_out, 0);
        req_in = 8'h01; step(2);
        ack_expect("R4 R6 base 1F line0", 8'hF8);
        step(3);
        chk("R7 held line in service", irq_out, 0);
        send_eoi(3'd0);
        step(1);
        chk("R6 re-request after EOI", irq_out, 1);
        req_in = '0; step(2);
        chk("R6 drop again", irq_out, 0);
    endtask

    task automatic t_mask_service;
        do_reset(1'b0, 1'b0);
        write_mask(8'h00);
        req_in = 8'h04; step(2); req_in = '0;
        ack_expect("R10 line2", 8'h22);
        write_mask(8'hFF);
        write_mask(8'h00);
        req_in = 8'h20; step(1); req_in = '0;
        step(3);
        chk("R10 service kept over mask writes", irq_out, 0);
        send_eoi(3'd2);
        step(1);
        chk("R10 line5 after EOI", irq_out, 1);
        write_mask(8'h20);
        step(1);
        chk("R2 masking withdraws", irq_out, 0);
    endtask

    task automatic t_spurious;
        do_reset(1'b0, 1'b0);
        write_mask(8'h00);
        inta = 1'b1; step(1); inta = 1'b0;
        chk("R11 no vector", vec_valid, 0);
        step(1);
        chk("R11 still no vector", vec_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_edge_mask();
        t_priority_auto();
        t_nesting();
        t_level();
        t_mask_service();
        t_spurious();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule